// File: doc/BRIEF.md
# Victim Line Store for a Direct-Mapped Primary Cache

This block is a small fully associative side store placed next to a direct-mapped primary cache. Each line that the primary cache throws out of a set is handed to the block on the eviction input. When the primary cache misses, it probes the block with the line address before it sends anything to the second level. A probe hit returns the line so the primary cache can refill from it. The line that the primary set gives up in the same operation takes over the slot that the returned line leaves. The block thus adds a few extra ways to the sets that conflict most, at almost no storage cost.

The store holds 4 or 8 lines. While a free slot exists, a new line goes into the lowest free slot. Once every slot holds a line, a round-robin pointer picks the slot to overwrite. A dirty line pushed out this way appears on the write-back output so it can be sent to the next level. Probe responses and write-backs are registered and appear one cycle after the inputs that cause them.

Top module: `victim_cache`

## Requirements
- R1: After reset every slot is empty: `resp_valid` and `wb_valid` are 0, and any probe misses until a line is inserted.
- R2: A line given on the eviction input (with no probe hit in that cycle) is stored, and a later probe of its address hits with the same data and dirty flag.
- R3: `resp_valid` is 1 in exactly the cycle after a cycle with `probe_valid` = 1, and 0 otherwise.
- R4: A probe whose address matches no stored line and no concurrent eviction returns `resp_hit` = 0 and `resp_data` = 0, and leaves the stored lines unchanged.
- R5: A probe hit with a concurrent eviction swaps the two lines: the found line is returned, the evicted line takes over its slot, no other slot changes and no write-back occurs.
- R6: A probe hit with no concurrent eviction returns the line and empties its slot, so that a second probe of that address misses.
- R7: While any slot is empty, an inserted line fills the lowest-numbered empty slot and nothing is written back; the store holds ENTRIES lines at most.
- R8: When all slots are full, an inserted line overwrites the slot at a round-robin pointer. The pointer is 0 after reset and advances by one, modulo ENTRIES, only on such an overwrite, so after a fill from empty the lines are displaced oldest first.
- R9: An overwritten line that is dirty appears one cycle later on `wb_valid` = 1 with its address and data. An overwritten clean line produces `wb_valid` = 0.
- R10: When a probe and an eviction carry the same address in one cycle, the response hits with the eviction's data and dirty flag. The line is not stored, because it returns to the primary cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evict_valid | input | 1 | A line leaves the primary cache this cycle |
| evict_addr | input | LINE_ADDR_W | Line address of the evicted line |
| evict_data | input | LINE_DATA_W | Contents of the evicted line |
| evict_dirty | input | 1 | Evicted line is modified |
| probe_valid | input | 1 | Primary-cache miss probes the store |
| probe_addr | input | LINE_ADDR_W | Line address being probed |
| resp_valid | output | 1 | Probe response present (one cycle after probe) |
| resp_hit | output | 1 | Probed line was found |
| resp_data | output | LINE_DATA_W | Returned line contents (0 on a miss) |
| resp_dirty | output | 1 | Returned line is modified |
| wb_valid | output | 1 | A dirty line was pushed out |
| wb_addr | output | LINE_ADDR_W | Address of the pushed-out line |
| wb_data | output | LINE_DATA_W | Contents of the pushed-out line |

## Verification
The hardest state to reach from the ports is a full store with holes punched by probe hits. In that state the lowest-free fill and the round-robin pointer pull in different directions, and the pointer can point at a line that is younger than others. The stimulus reaches it with a sweep over every pairing of probe and eviction addresses drawn from a pool three times the capacity, under all four combinations of the two valid strobes. That mix of swaps, drops, fills, overwrites and same-address bypasses runs against an arithmetic model of the slots kept in the bench. Evictions are suppressed whenever the address is already held, just as a real primary cache never evicts a line the store still owns.

// File: rtl/vc_pkg.sv
package vc_pkg;

   // action chosen for one cycle of inputs
   typedef enum logic [2:0] {
      VC_IDLE   = 3'd0,
      VC_FILL   = 3'd1,
      VC_SWAP   = 3'd2,
      VC_DROP   = 3'd3,
      VC_BYPASS = 3'd4
   } vc_act_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
   parameter int unsigned N  = 4,
   parameter int unsigned AW = 8
) (
   input  logic                  en,
   input  logic [N-1:0]          vld,
   input  logic [N-1:0][AW-1:0]  tag,
   input  logic [AW-1:0]         key,
   output logic                  hit,
   output logic [vc_pkg::idx_w(N)-1:0] hit_idx
);
   localparam int unsigned IW = vc_pkg::idx_w(N);

   logic [N-1:0] hit_vec;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = en & vld[g] & (tag[g] == key);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IW'(i);
      end
   end

endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
   parameter int unsigned N             = 4,
   parameter bit          FILL_FROM_LOW = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N-1:0]                vld,
   input  logic                        advance,
   output logic                        full,
   output logic [vc_pkg::idx_w(N)-1:0] slot
);
   localparam int unsigned IW = vc_pkg::idx_w(N);

   logic [IW-1:0] free_idx;
   logic [IW-1:0] rr_q;

   if (FILL_FROM_LOW) begin : g_low
      always_comb begin
         free_idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IW'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         free_idx = '0;
         for (int i = 0; i < N; i++) begin
            if (!vld[i]) free_idx = IW'(i);
         end
      end
   end

   assign full = &vld;
   assign slot = full ? rr_q : free_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (advance) begin
         if (rr_q == IW'(N - 1)) rr_q <= '0;
         else                    rr_q <= rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/vc_store.sv
module vc_store #(
   parameter int unsigned N  = 4,
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [vc_pkg::idx_w(N)-1:0] wr_idx,
   input  logic [AW-1:0]               wr_addr,
   input  logic [DW-1:0]               wr_data,
   input  logic                        wr_dirty,
   input  logic                        clr_en,
   input  logic [vc_pkg::idx_w(N)-1:0] clr_idx,
   output logic [N-1:0]                vld,
   output logic [N-1:0][AW-1:0]        addr,
   output logic [N-1:0][DW-1:0]        data,
   output logic [N-1:0]                dirty
);
   localparam int unsigned IW = vc_pkg::idx_w(N);

   for (genvar g = 0; g < N; g++) begin : g_slot
      logic          v_q;
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      logic          m_q;
      logic          sel_wr;
      logic          sel_clr;

      assign sel_wr  = wr_en  && (wr_idx  == IW'(g));
      assign sel_clr = clr_en && (clr_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            a_q <= '0;
            d_q <= '0;
            m_q <= 1'b0;
         end else if (sel_wr) begin
            v_q <= 1'b1;
            a_q <= wr_addr;
            d_q <= wr_data;
            m_q <= wr_dirty;
         end else if (sel_clr) begin
            v_q <= 1'b0;
            m_q <= 1'b0;
         end
      end

      assign vld[g]   = v_q;
      assign addr[g]  = a_q;
      assign data[g]  = d_q;
      assign dirty[g] = m_q;
   end

endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
   parameter int unsigned ENTRIES       = 4,
   parameter int unsigned LINE_ADDR_W   = 26,
   parameter int unsigned LINE_DATA_W   = 128,
   parameter bit          FILL_FROM_LOW = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   evict_valid,
   input  logic [LINE_ADDR_W-1:0] evict_addr,
   input  logic [LINE_DATA_W-1:0] evict_data,
   input  logic                   evict_dirty,
   input  logic                   probe_valid,
   input  logic [LINE_ADDR_W-1:0] probe_addr,
   output logic                   resp_valid,
   output logic                   resp_hit,
   output logic [LINE_DATA_W-1:0] resp_data,
   output logic                   resp_dirty,
   output logic                   wb_valid,
   output logic [LINE_ADDR_W-1:0] wb_addr,
   output logic [LINE_DATA_W-1:0] wb_data
);
   import vc_pkg::*;

   localparam int unsigned IW = idx_w(ENTRIES);

   if (ENTRIES != 4 && ENTRIES != 8) begin : g_bad_entries
      $error("victim_cache: ENTRIES must be 4 or 8");
   end
   if (LINE_ADDR_W < 1 || LINE_DATA_W < 1) begin : g_bad_width
      $error("victim_cache: line widths must be positive");
   end

   logic [ENTRIES-1:0]                  st_vld;
   logic [ENTRIES-1:0][LINE_ADDR_W-1:0] st_addr;
   logic [ENTRIES-1:0][LINE_DATA_W-1:0] st_data;
   logic [ENTRIES-1:0]                  st_dirty;

   logic          hit;
   logic [IW-1:0] hit_idx;
   logic          full;
   logic [IW-1:0] slot;
   logic          bypass;
   vc_act_e       act;
   logic          wr_en;
   logic [IW-1:0] wr_idx;
   logic          clr_en;
   logic          advance;
   logic          push;

   vc_match #(.N(ENTRIES), .AW(LINE_ADDR_W)) u_match (
      .en      (probe_valid),
      .vld     (st_vld),
      .tag     (st_addr),
      .key     (probe_addr),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   vc_alloc #(.N(ENTRIES), .FILL_FROM_LOW(FILL_FROM_LOW)) u_alloc (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (st_vld),
      .advance (advance),
      .full    (full),
      .slot    (slot)
   );

   // same-address probe and eviction: the line goes straight back
   assign bypass = probe_valid & evict_valid & (evict_addr == probe_addr);

   always_comb begin
      if (bypass)           act = VC_BYPASS;
      else if (hit)         act = evict_valid ? VC_SWAP : VC_DROP;
      else if (evict_valid) act = VC_FILL;
      else                  act = VC_IDLE;
   end

   assign wr_en   = (act == VC_SWAP) || (act == VC_FILL);
   assign wr_idx  = (act == VC_SWAP) ? hit_idx : slot;
   assign clr_en  = (act == VC_DROP);
   assign advance = (act == VC_FILL) && full;
   assign push    = advance && st_dirty[slot];

   vc_store #(.N(ENTRIES), .AW(LINE_ADDR_W), .DW(LINE_DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_addr  (evict_addr),
      .wr_data  (evict_data),
      .wr_dirty (evict_dirty),
      .clr_en   (clr_en),
      .clr_idx  (hit_idx),
      .vld      (st_vld),
      .addr     (st_addr),
      .data     (st_data),
      .dirty    (st_dirty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_data  <= '0;
         resp_dirty <= 1'b0;
      end else begin
         resp_valid <= probe_valid;
         resp_hit   <= bypass | hit;
         if (bypass) begin
            resp_data  <= evict_data;
            resp_dirty <= evict_dirty;
         end else if (hit) begin
            resp_data  <= st_data[hit_idx];
            resp_dirty <= st_dirty[hit_idx];
         end else begin
            resp_data  <= '0;
            resp_dirty <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= push;
         if (push) begin
            wb_addr <= st_addr[slot];
            wb_data <= st_data[slot];
         end
      end
   end

endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          evict_valid,
   input logic [AW-1:0] evict_addr,
   input logic [DW-1:0] evict_data,
   input logic          evict_dirty,
   input logic          probe_valid,
   input logic [AW-1:0] probe_addr,
   input logic          resp_valid,
   input logic          resp_hit,
   input logic [DW-1:0] resp_data,
   input logic          resp_dirty,
   input logic          wb_valid
);

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!resp_valid && !wb_valid));

   a_r3_resp_follows_probe: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |=> resp_valid);

   a_r3_no_unasked_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !probe_valid |=> !resp_valid);

   a_r4_hit_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
      resp_hit |-> resp_valid);

   a_r4_miss_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (resp_data == '0 && !resp_dirty));

   a_r5_hit_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      resp_hit |-> !wb_valid);

   a_r9_wb_needs_eviction: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(evict_valid));

   a_r10_bypass_sees_line: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid && evict_valid && probe_addr == evict_addr) |=>
         (resp_hit && resp_data == $past(evict_data) && resp_dirty == $past(evict_dirty)));

endmodule

bind victim_cache vc_checker #(.AW(LINE_ADDR_W), .DW(LINE_DATA_W)) u_vc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evict_valid (evict_valid),
   .evict_addr  (evict_addr),
   .evict_data  (evict_data),
   .evict_dirty (evict_dirty),
   .probe_valid (probe_valid),
   .probe_addr  (probe_addr),
   .resp_valid  (resp_valid),
   .resp_hit    (resp_hit),
   .resp_data   (resp_data),
   .resp_dirty  (resp_dirty),
   .wb_valid    (wb_valid)
);

// File: tb/victim_cache_test.sv
module victim_cache_test;
   localparam time         CLK_P = 10;
   localparam int unsigned N     = 4;
   localparam int unsigned AW    = 8;
   localparam int unsigned DW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evict_valid = 1'b0;
   logic [AW-1:0] evict_addr = '0;
   logic [DW-1:0] evict_data = '0;
   logic          evict_dirty = 1'b0;
   logic          probe_valid = 1'b0;
   logic [AW-1:0] probe_addr = '0;
   logic          resp_valid, resp_hit, resp_dirty, wb_valid;
   logic [DW-1:0] resp_data, wb_data;
   logic [AW-1:0] wb_addr;

   int vectors = 0;
   int fails   = 0;
   logic [7:0] salt = 8'h01;

   // slot model built from the requirements
   logic          mv [N];
   logic [AW-1:0] ma [N];
   logic [DW-1:0] md [N];
   logic          mdr[N];
   int            mrr;

   always #(CLK_P/2) clk = ~clk;

   victim_cache #(.ENTRIES(N), .LINE_ADDR_W(AW), .LINE_DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .evict_data(evict_data), .evict_dirty(evict_dirty),
      .probe_valid(probe_valid), .probe_addr(probe_addr),
      .resp_valid(resp_valid), .resp_hit(resp_hit),
      .resp_data(resp_data), .resp_dirty(resp_dirty),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit held(input logic [AW-1:0] a);
      for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         mv[i] = 1'b0; ma[i] = '0; md[i] = '0; mdr[i] = 1'b0;
      end
      mrr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      evict_valid = 1'b0;
      probe_valid = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      check(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 0);
      check(wb_valid == 1'b0, "R1", "wb_valid in reset", 32'(wb_valid), 0);
      rst_n = 1'b1;
   endtask

   // one cycle of stimulus, compared against the model one cycle later
   task automatic apply(input logic l_v, input logic [AW-1:0] l_a,
                        input logic e_v, input logic [AW-1:0] e_a,
                        input logic e_dr, input string tag_in);
      logic [DW-1:0] e_d;
      logic          x_hit, x_dr, x_wb;
      logic [DW-1:0] x_d, x_wd;
      logic [AW-1:0] x_wa;
      int            hi, fr;
      string         tag;
      e_d = {e_a, salt};
      salt = salt + 8'd1;
      @(negedge clk);
      probe_valid = l_v;  probe_addr = l_a;
      evict_valid = e_v;  evict_addr = e_a;
      evict_data  = e_d;  evict_dirty = e_dr;
      x_hit = 0; x_dr = 0; x_d = '0; x_wb = 0; x_wa = '0; x_wd = '0;
      hi = -1;
      for (int i = 0; i < N; i++)
         if (l_v && mv[i] && ma[i] == l_a && hi < 0) hi = i;
      if (l_v && e_v && e_a == l_a) begin
         tag = "R10";
         x_hit = 1; x_d = e_d; x_dr = e_dr;
      end else if (hi >= 0) begin
         x_hit = 1; x_d = md[hi]; x_dr = mdr[hi];
         if (e_v) begin
            tag = "R5";
            ma[hi] = e_a; md[hi] = e_d; mdr[hi] = e_dr;
         end else begin
            tag = "R6";
            mv[hi] = 1'b0;
         end
      end else begin
         tag = l_v ? "R4" : "R2";
         if (e_v) begin
            fr = -1;
            for (int i = 0; i < N; i++) if (!mv[i] && fr < 0) fr = i;
            if (fr < 0) begin
               fr = mrr;
               mrr = (mrr + 1) % N;
               if (mdr[fr]) begin
                  x_wb = 1; x_wa = ma[fr]; x_wd = md[fr];
               end
            end
            mv[fr] = 1'b1; ma[fr] = e_a; md[fr] = e_d; mdr[fr] = e_dr;
         end
      end
      if (tag_in != "") tag = tag_in;
      @(posedge clk);
      #(CLK_P/4);
      check(resp_valid == l_v, "R3", "resp_valid", 32'(resp_valid), 32'(l_v));
      if (l_v) begin
         check(resp_hit == x_hit, tag, "resp_hit", 32'(resp_hit), 32'(x_hit));
         check(resp_data == x_d, tag, "resp_data", 32'(resp_data), 32'(x_d));
         check(resp_dirty == x_dr, tag, "resp_dirty", 32'(resp_dirty), 32'(x_dr));
      end
      check(wb_valid == x_wb, "R9", "wb_valid", 32'(wb_valid), 32'(x_wb));
      if (x_wb) begin
         check(wb_addr == x_wa, "R8", "wb_addr", 32'(wb_addr), 32'(x_wa));
         check(wb_data == x_wd, "R9", "wb_data", 32'(wb_data), 32'(x_wd));
      end
      probe_valid = 1'b0;
      evict_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic ev_ok;
      do_reset();
      // R1: empty store misses everywhere
      for (int a = 0; a < 8; a++) apply(1'b1, AW'(a), 1'b0, '0, 1'b0, "R1");
      // R7: fill from empty, lowest slot first, no write-back
      for (int a = 0; a < N; a++) apply(1'b0, '0, 1'b1, AW'(8'h10 + a), a[0] == 1'b0, "R7");
      // R8/R9: overwrites of a full store, oldest first (dirty, clean, dirty, clean)
      for (int a = 0; a < N; a++) apply(1'b0, '0, 1'b1, AW'(8'h20 + a), 1'b1, "R8");
      // R2: the newest lines are all present; R6: a hit empties the slot
      apply(1'b1, 8'h21, 1'b0, '0, 1'b0, "R2");
      apply(1'b1, 8'h21, 1'b0, '0, 1'b0, "R6");
      // R7: the hole is refilled before any overwrite
      apply(1'b0, '0, 1'b1, 8'h30, 1'b1, "R7");
      // R5: swap a held line with an evicted one
      apply(1'b1, 8'h22, 1'b1, 8'h31, 1'b0, "R5");
      apply(1'b1, 8'h31, 1'b0, '0, 1'b0, "R5");
      apply(1'b1, 8'h22, 1'b0, '0, 1'b0, "R5");
      // R10: same address on both inputs, then not stored
      apply(1'b1, 8'h40, 1'b1, 8'h40, 1'b1, "R10");
      apply(1'b1, 8'h40, 1'b0, '0, 1'b0, "R10");
      // R1: a second reset empties the store
      do_reset();
      for (int a = 0; a < 4; a++) apply(1'b1, AW'(8'h20 + a), 1'b0, '0, 1'b0, "R1");
      // sweep every probe/eviction address pair and strobe combination
      for (int la = 0; la < 3 * N; la++) begin
         for (int ea = 0; ea < 3 * N; ea++) begin
            for (int m = 0; m < 4; m++) begin
               ev_ok = m[1] && !held(AW'(ea));
               apply(m[0], AW'(la), ev_ok, AW'(ea), ((la * 3 + ea) % 2) == 1, "");
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule